// File: doc/BRIEF.md
# Per-Address Request Parking Buffer

This block holds requests that a cache controller has decided cannot proceed yet, because another transaction to the same address is still outstanding (an atomic in flight, or a dirty line being written back). The controller does not retry such a request every cycle. It pushes the request here with its address and payload and forgets about it. Parked requests sit idle and take no pipeline slots, so a crowd of blocked requests can no longer starve the transaction they are waiting for.

When the outstanding transaction returns, the controller presents its address on the wakeup port. Every parked request with that address is then marked runnable, wherever it sits in the buffer, and the runnable requests are handed back to the controller's request input, oldest first and one per cycle, under a valid/ready handshake. Loads and atomics are both returned whole, so the controller runs them again instead of dropping them. When every slot is occupied, the enqueue side drops its ready signal and the upstream channel waits. Deciding which requests must park is not part of this block.

Top module: `stall_wake_buffer`

## Requirements
- R1: After reset the buffer is empty: `enq_ready` is 1 and `rel_valid` is 0.
- R2: A request is accepted on a clock edge where `enq_valid` and `enq_ready` are both 1, and it is never offered on the release port until a wakeup carrying its address has been seen.
- R3: With all DEPTH slots occupied, `enq_ready` is 0 and a request presented on `enq_valid` is neither stored nor allowed to overwrite a parked one.
- R4: A wakeup marks every parked request whose address equals `wake_addr` as runnable, whichever slot each one occupies.
- R5: A wakeup never makes a request with a different address runnable.
- R6: Runnable requests leave oldest first in arrival order, at most one per cycle; with `rel_ready` held at 1, consecutive runnable requests leave on consecutive cycles.
- R7: While `rel_valid` is 1 and `rel_ready` is 0, `rel_valid` stays 1 and `rel_addr` and `rel_payload` hold their values on the next cycle.
- R8: A released request carries exactly the address and payload it was parked with, whatever kind of operation the payload encodes (load or atomic).
- R9: A request accepted on the same edge as a wakeup for its own address is not made runnable by that wakeup; it needs a later wakeup.
- R10: A wakeup whose address matches no parked request changes nothing: no release follows and the parked requests stay parked.
- R11: The slot freed by a release accepts a new request from the next cycle on, so `enq_ready` returns to 1 one cycle after a release from a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enq_valid | input | 1 | A request to park is presented |
| enq_ready | output | 1 | A free slot exists; the request is taken on this edge |
| enq_addr | input | ADDR_W | Address the request waits on |
| enq_payload | input | PAYLOAD_W | Opaque request contents |
| wake_valid | input | 1 | A pending transaction has returned |
| wake_addr | input | ADDR_W | Address of the returned transaction |
| rel_valid | output | 1 | A runnable request is offered back |
| rel_ready | input | 1 | The controller takes the offered request |
| rel_addr | output | ADDR_W | Address of the offered request |
| rel_payload | output | PAYLOAD_W | Payload of the offered request |

## Verification
On every cycle the assertions compare the ready signal against an occupancy count rebuilt from the two handshakes, forbid any offer while that count is zero, require every rising offer to follow a wakeup, and require a stalled offer to stay unchanged. Which requests a given wakeup releases, and in what order, depends on addresses and arrival history that a one-cycle property cannot hold, so per-address isolation, oldest-first order across slots, the same-edge enqueue and wakeup case, and the ignored push into a full buffer are shown by the bench's directed scenarios.

// File: rtl/swb_pkg.sv
package swb_pkg;

  // State of the release port: free to pick a new winner, or pinned to the
  // entry that was offered and not yet taken.
  typedef enum logic {
    HOLD_FREE = 1'b0,
    HOLD_KEEP = 1'b1
  } hold_e;

endpackage

// File: rtl/swb_free_pick.sv
// Finds the lowest-numbered empty slot.
module swb_free_pick #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]         busy,
  output logic                     found,
  output logic [$clog2(DEPTH)-1:0] idx
);
  localparam int IDX_W = $clog2(DEPTH);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/swb_age_tracker.sv
// Relative-age matrix: older_q[j][i] is set when slot j was filled before
// slot i. Picks the oldest candidate in a single combinational level.
module swb_age_tracker #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic [DEPTH-1:0]         live,
  input  logic [DEPTH-1:0]         cand,
  output logic                     pick_any,
  output logic [$clog2(DEPTH)-1:0] pick_idx
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][DEPTH-1:0] older_q, older_d;
  logic [DEPTH-1:0]            win;

  // next state
  always_comb begin
    older_d = older_q;
    if (alloc_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        older_d[alloc_idx][j] = 1'b0;
        older_d[j][alloc_idx] = live[j] && (IDX_W'(j) != alloc_idx);
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (alloc_en) begin
      older_q <= older_d;
    end
  end

  // a candidate wins when no other candidate is older than it
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        beaten = beaten | (cand[j] & older_q[j][i]);
      end
      win[i] = cand[i] & ~beaten;
    end
  end

  always_comb begin
    pick_any = |win;
    pick_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (win[i]) pick_idx = pick_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/swb_entry_store.sv
// Slot storage: occupancy, runnable flag, address and payload per slot.
module swb_entry_store #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 12,
  parameter int PAYLOAD_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [$clog2(DEPTH)-1:0]            wr_idx,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [PAYLOAD_W-1:0]                wr_payload,
  input  logic                                wake_en,
  input  logic [ADDR_W-1:0]                   wake_addr,
  input  logic                                clr_en,
  input  logic [$clog2(DEPTH)-1:0]            clr_idx,
  output logic [DEPTH-1:0]                    live,
  output logic [DEPTH-1:0]                    armed,
  output logic [DEPTH-1:0][ADDR_W-1:0]        addr,
  output logic [DEPTH-1:0][PAYLOAD_W-1:0]     payload
);
  localparam int IDX_W = $clog2(DEPTH);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic                 live_q,  live_d;
    logic                 armed_q, armed_d;
    logic [ADDR_W-1:0]    addr_q;
    logic [PAYLOAD_W-1:0] pay_q;
    logic                 fill, drop, hit;

    assign fill = wr_en  && (wr_idx  == IDX_W'(g));
    assign drop = clr_en && (clr_idx == IDX_W'(g));
    // only requests resident before this edge can match a wakeup
    assign hit  = wake_en && live_q && (addr_q == wake_addr);

    always_comb begin
      live_d  = live_q;
      armed_d = armed_q;
      if (drop) begin
        live_d  = 1'b0;
        armed_d = 1'b0;
      end else if (fill) begin
        live_d  = 1'b1;
        armed_d = 1'b0;
      end else if (hit) begin
        armed_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q  <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        live_q  <= live_d;
        armed_q <= armed_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        pay_q  <= '0;
      end else if (fill) begin
        addr_q <= wr_addr;
        pay_q  <= wr_payload;
      end
    end

    assign live[g]    = live_q;
    assign armed[g]   = armed_q;
    assign addr[g]    = addr_q;
    assign payload[g] = pay_q;
  end
endmodule

// File: rtl/stall_wake_buffer.sv
// Parks blocked requests per address and returns them after a wakeup.
module stall_wake_buffer #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 12,
  parameter int PAYLOAD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq_valid,
  output logic                 enq_ready,
  input  logic [ADDR_W-1:0]    enq_addr,
  input  logic [PAYLOAD_W-1:0] enq_payload,
  input  logic                 wake_valid,
  input  logic [ADDR_W-1:0]    wake_addr,
  output logic                 rel_valid,
  input  logic                 rel_ready,
  output logic [ADDR_W-1:0]    rel_addr,
  output logic [PAYLOAD_W-1:0] rel_payload
);
  import swb_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]                live, armed;
  logic [DEPTH-1:0][ADDR_W-1:0]    s_addr;
  logic [DEPTH-1:0][PAYLOAD_W-1:0] s_pay;
  logic                            has_free;
  logic [IDX_W-1:0]                free_idx;
  logic                            pick_any;
  logic [IDX_W-1:0]                pick_idx;
  logic                            enq_fire, rel_fire;
  logic [IDX_W-1:0]                sel_idx;

  hold_e            hold_q, hold_d;
  logic [IDX_W-1:0] hold_idx_q, hold_idx_d;

  swb_free_pick #(.DEPTH(DEPTH)) u_free (
    .busy  (live),
    .found (has_free),
    .idx   (free_idx)
  );

  assign enq_ready = has_free;
  assign enq_fire  = enq_valid && has_free;

  swb_entry_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (enq_fire),
    .wr_idx     (free_idx),
    .wr_addr    (enq_addr),
    .wr_payload (enq_payload),
    .wake_en    (wake_valid),
    .wake_addr  (wake_addr),
    .clr_en     (rel_fire),
    .clr_idx    (sel_idx),
    .live       (live),
    .armed      (armed),
    .addr       (s_addr),
    .payload    (s_pay)
  );

  swb_age_tracker #(.DEPTH(DEPTH)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (enq_fire),
    .alloc_idx (free_idx),
    .live      (live),
    .cand      (armed),
    .pick_any  (pick_any),
    .pick_idx  (pick_idx)
  );

  // release port: a stalled offer stays pinned to its slot
  assign sel_idx     = (hold_q == HOLD_KEEP) ? hold_idx_q : pick_idx;
  assign rel_valid   = (hold_q == HOLD_KEEP) || pick_any;
  assign rel_fire    = rel_valid && rel_ready;
  assign rel_addr    = s_addr[sel_idx];
  assign rel_payload = s_pay[sel_idx];

  always_comb begin
    hold_d     = HOLD_FREE;
    hold_idx_d = hold_idx_q;
    if (rel_valid && !rel_ready) begin
      hold_d     = HOLD_KEEP;
      hold_idx_d = sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= HOLD_FREE;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= hold_d;
      hold_idx_q <= hold_idx_d;
    end
  end
endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 12,
  parameter int PAYLOAD_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enq_valid,
  input logic                 enq_ready,
  input logic                 wake_valid,
  input logic                 rel_valid,
  input logic                 rel_ready,
  input logic [ADDR_W-1:0]    rel_addr,
  input logic [PAYLOAD_W-1:0] rel_payload
);
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ;

  // occupancy rebuilt from the two handshakes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      occ <= occ + OCC_W'(enq_valid && enq_ready) - OCC_W'(rel_valid && rel_ready);
    end
  end

  // R3: ready tracks the room left, and occupancy never passes DEPTH
  p_ready_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_ready == (occ < OCC_W'(DEPTH))) && (occ <= OCC_W'(DEPTH)));

  // R2: nothing is offered while nothing is parked
  p_no_offer_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !rel_valid);

  // R2: an offer only appears after a wakeup
  p_offer_after_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_valid) |-> $past(wake_valid));

  // R7: a stalled offer holds steady
  p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_addr) && $stable(rel_payload)));
endmodule

bind stall_wake_buffer swb_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enq_valid   (enq_valid),
  .enq_ready   (enq_ready),
  .wake_valid  (wake_valid),
  .rel_valid   (rel_valid),
  .rel_ready   (rel_ready),
  .rel_addr    (rel_addr),
  .rel_payload (rel_payload)
);

// File: tb/stall_wake_buffer_tb.sv
module stall_wake_buffer_tb;
  localparam int DEPTH = 8;
  localparam int AW    = 12;
  localparam int PW    = 16;
  localparam logic [PW-1:0] ATOM = 16'h8000; // payload bit 15 marks an atomic

  logic          clk, rst_n;
  logic          enq_valid, enq_ready;
  logic [AW-1:0] enq_addr;
  logic [PW-1:0] enq_payload;
  logic          wake_valid;
  logic [AW-1:0] wake_addr;
  logic          rel_valid, rel_ready;
  logic [AW-1:0] rel_addr;
  logic [PW-1:0] rel_payload;

  int n_chk, n_bad;

  stall_wake_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .PAYLOAD_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .enq_payload(enq_payload),
    .wake_valid(wake_valid), .wake_addr(wake_addr),
    .rel_valid(rel_valid), .rel_ready(rel_ready),
    .rel_addr(rel_addr), .rel_payload(rel_payload)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic push(input logic [AW-1:0] a, input logic [PW-1:0] p);
    enq_valid = 1'b1; enq_addr = a; enq_payload = p;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic wake(input logic [AW-1:0] a);
    wake_valid = 1'b1; wake_addr = a;
    @(negedge clk);
    wake_valid = 1'b0;
  endtask

  task automatic take(input logic [AW-1:0] a, input logic [PW-1:0] p, input string req);
    rel_ready = 1'b1;
    #1;
    chk(rel_valid == 1'b1, req, "offer valid", rel_valid, 1);
    chk(rel_addr == a, req, "offer addr", rel_addr, a);
    chk(rel_payload == p, req, "offer payload", rel_payload, p);
    @(negedge clk);
    rel_ready = 1'b0;
  endtask

  task automatic quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      rel_ready = 1'b1;
      #1;
      chk(rel_valid == 1'b0, req, "no offer", rel_valid, 0);
      @(negedge clk);
      rel_ready = 1'b0;
    end
  endtask

  task automatic t_reset();
    #1;
    chk(enq_ready == 1'b1, "R1", "ready after reset", enq_ready, 1);
    chk(rel_valid == 1'b0, "R1", "offer after reset", rel_valid, 0);
  endtask

  // R2 R4 R5 R6 R8: interleaved addresses, only the woken one leaves, in order
  task automatic t_order();
    push(12'h0A0, 16'h0001);
    push(12'h0B0, 16'h0002);
    push(12'h0A0, 16'h0003);
    push(12'h0B0, 16'h0004);
    push(12'h0A0, ATOM | 16'h0005);
    quiet(3, "R2");
    wake(12'h0A0);
    take(12'h0A0, 16'h0001, "R6");
    take(12'h0A0, 16'h0003, "R4");
    take(12'h0A0, ATOM | 16'h0005, "R8");
    quiet(2, "R5");
    wake(12'h0B0);
    take(12'h0B0, 16'h0002, "R6");
    take(12'h0B0, 16'h0004, "R6");
    quiet(1, "R5");
  endtask

  // R3 R11: fill, refused push, slot reuse
  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(12'h010, 16'(16'h0100 + i));
    #1;
    chk(enq_ready == 1'b0, "R3", "ready when full", enq_ready, 0);
    push(12'h010, 16'h0999);
    wake(12'h010);
    take(12'h010, 16'h0100, "R11");
    #1;
    chk(enq_ready == 1'b1, "R11", "ready after release", enq_ready, 1);
    for (int i = 1; i < DEPTH; i++) take(12'h010, 16'(16'h0100 + i), "R3");
    quiet(2, "R3");
  endtask

  // R7: stalled offer holds
  task automatic t_backpressure();
    push(12'h0C0, ATOM | 16'h0007);
    wake(12'h0C0);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(rel_valid == 1'b1, "R7", "held valid", rel_valid, 1);
      chk(rel_payload == (ATOM | 16'h0007), "R7", "held payload", rel_payload, ATOM | 16'h0007);
      @(negedge clk);
    end
    take(12'h0C0, ATOM | 16'h0007, "R7");
    quiet(1, "R7");
  endtask

  // R9: enqueue on the same edge as a wakeup for its address
  task automatic t_same_edge();
    push(12'h0D0, 16'h0011);
    enq_valid = 1'b1; enq_addr = 12'h0D0; enq_payload = 16'h0012;
    wake_valid = 1'b1; wake_addr = 12'h0D0;
    @(negedge clk);
    enq_valid = 1'b0; wake_valid = 1'b0;
    take(12'h0D0, 16'h0011, "R9");
    quiet(2, "R9");
    wake(12'h0D0);
    take(12'h0D0, 16'h0012, "R9");
  endtask

  // R10: wakeup that hits nothing
  task automatic t_miss();
    push(12'h0E0, 16'h0009);
    wake(12'h0F0);
    quiet(2, "R10");
    wake(12'h0E0);
    take(12'h0E0, 16'h0009, "R10");
    quiet(1, "R10");
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    enq_valid = 1'b0; enq_addr = '0; enq_payload = '0;
    wake_valid = 1'b0; wake_addr = '0; rel_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_backpressure();
    t_same_edge();
    t_miss();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule